// File: doc/BRIEF.md
# Processor Operating Mode Tracker

This block keeps track of the execution mode a processor core is in. It watches the level of two control bits, protection enable and the virtual-8086 flag, together with two single-cycle requests: a management interrupt and a return from management mode. From these it computes the current mode. There are four modes: real-address, protected, virtual-8086 and a management mode. Any of the other three modes can enter management mode, and a return from it goes back to exactly the mode that was interrupted.

When management mode is entered, the interrupted mode is copied into a saved-mode register. That register does not change again until the return. If a management interrupt arrives while the block is already in management mode, it is not nested. It is remembered as pending and is taken once, on the cycle right after the return. A return request outside management mode changes nothing, apart from a one-cycle illegal-request pulse. The asynchronous active-low reset is released through a two-stage synchronizer. Reset always lands the block in real-address mode.

Top module: `cpu_mode_tracker`

## Requirements
- R1: While reset is active and after it is released, the mode code is 0 (real-address), the saved mode is 0, nothing is pending and the illegal pulse is low.
- R2: In real-address mode with cr_pe high, the mode becomes protected (code 1) on the next clock.
- R3: In protected mode with cr_pe low and cr_vm low, the mode becomes real-address on the next clock.
- R4: In protected mode with cr_pe and cr_vm both high, the mode becomes virtual-8086 (code 2) on the next clock. In virtual-8086 mode with cr_vm low, it returns to protected.
- R5: A management request (smi_req high, or a pending one) in modes 0, 1 or 2 moves the block to management mode (code 3) on the next clock, and saved_mode then holds the interrupted mode. This takes priority over flag-driven transitions.
- R6: A return request (rsm_req) in management mode restores the mode held in saved_mode on the next clock.
- R7: saved_mode does not change while the block stays in management mode.
- R8: smi_req while in management mode raises smi_pending on the next clock and does not leave management mode. The pending request is taken on the clock right after the return.
- R9: rsm_req outside management mode does not change the mode. It raises rsm_illegal for exactly the next cycle.
- R10: cr_vm is ignored in real-address mode, and cr_pe and cr_vm are ignored in virtual-8086 and management modes except as R4 states.
- R11: mode_onehot has exactly bit mode_code set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_pe | input | 1 | Protection-enable bit level |
| cr_vm | input | 1 | Virtual-8086 flag level |
| smi_req | input | 1 | Management interrupt request |
| rsm_req | input | 1 | Return-from-management request |
| mode_code | output | 2 | Current mode: 0 real, 1 protected, 2 virtual-8086, 3 management |
| mode_onehot | output | 4 | One-hot form of mode_code |
| saved_mode | output | 2 | Mode interrupted by the last management entry |
| smi_pending | output | 1 | Management request held during management mode |
| rsm_illegal | output | 1 | One-cycle pulse for a return outside management mode |

## Verification
Every result is registered once: a request or flag level applied before a rising edge shows up in mode_code, saved_mode, smi_pending and rsm_illegal right after that edge. A pending management request takes a second edge, one to return and one to re-enter. The bench drives inputs at the falling edge and steps a reference model one cycle per edge. It compares all outputs 2 ns after the following rising edge. After reset release, the bench idles for several cycles to cover the synchronizer delay before it drives any stimulus.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MD_REAL = 2'd0,
    MD_PROT = 2'd1,
    MD_V86  = 2'd2,
    MD_MGMT = 2'd3
  } cpu_mode_e;
endpackage

// File: rtl/cmt_rst_sync.sv
module cmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmt_smi_pending.sv
module cmt_smi_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic in_mgmt,
  input  logic smi_req,
  input  logic take_smi,
  output logic pending
);
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = 1'b0;
    pend_d  = pending;
    if (in_mgmt && smi_req) begin
      pend_en = 1'b1;
      pend_d  = 1'b1;
    end else if (take_smi) begin
      pend_en = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (pend_en) pending <= pend_d;
  end
endmodule

// File: rtl/cmt_next_state.sv
module cmt_next_state
  import cmt_pkg::*;
(
  input  cpu_mode_e cur_mode,
  input  cpu_mode_e saved_q,
  input  logic      pending,
  input  logic      cr_pe,
  input  logic      cr_vm,
  input  logic      smi_req,
  input  logic      rsm_req,
  output cpu_mode_e nxt_mode,
  output logic      save_en,
  output logic      take_smi,
  output logic      illegal_d
);
  logic want_smi;

  always_comb begin
    want_smi  = smi_req || pending;
    nxt_mode  = cur_mode;
    save_en   = 1'b0;
    take_smi  = 1'b0;
    illegal_d = 1'b0;
    if (cur_mode == MD_MGMT) begin
      if (rsm_req) nxt_mode = saved_q;
    end else begin
      illegal_d = rsm_req;
      if (want_smi) begin
        nxt_mode = MD_MGMT;
        save_en  = 1'b1;
        take_smi = 1'b1;
      end else begin
        unique case (cur_mode)
          MD_REAL: if (cr_pe) nxt_mode = MD_PROT;
          MD_PROT: begin
            if (!cr_pe)     nxt_mode = MD_REAL;
            else if (cr_vm) nxt_mode = MD_V86;
          end
          MD_V86:  if (!cr_vm) nxt_mode = MD_PROT;
          default: nxt_mode = cur_mode;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmt_decode.sv
module cmt_decode #(
  parameter int W = 2,
  parameter int N = 1 << W
) (
  input  logic [W-1:0] code,
  output logic [N-1:0] onehot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign onehot[i] = (code == W'(i));
  end
endmodule

// File: rtl/cpu_mode_tracker.sv
module cpu_mode_tracker
  import cmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cr_pe,
  input  logic                 cr_vm,
  input  logic                 smi_req,
  input  logic                 rsm_req,
  output logic [MODE_W-1:0]    mode_code,
  output logic [NUM_MODES-1:0] mode_onehot,
  output logic [MODE_W-1:0]    saved_mode,
  output logic                 smi_pending,
  output logic                 rsm_illegal
);
  logic      rst_n_int;
  cpu_mode_e mode_q, mode_d;
  cpu_mode_e saved_q;
  logic      save_en, take_smi, illegal_d, illegal_q;

  cmt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cmt_next_state u_nxt (
    .cur_mode(mode_q), .saved_q(saved_q), .pending(smi_pending),
    .cr_pe(cr_pe), .cr_vm(cr_vm), .smi_req(smi_req), .rsm_req(rsm_req),
    .nxt_mode(mode_d), .save_en(save_en), .take_smi(take_smi),
    .illegal_d(illegal_d)
  );

  cmt_smi_pending u_pend (
    .clk(clk), .rst_n(rst_n_int), .in_mgmt(mode_q == MD_MGMT),
    .smi_req(smi_req), .take_smi(take_smi), .pending(smi_pending)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mode_q    <= MD_REAL;
      illegal_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      illegal_q <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   saved_q <= MD_REAL;
    else if (save_en) saved_q <= mode_q;
  end

  cmt_decode #(.W(MODE_W), .N(NUM_MODES)) u_dec (
    .code(mode_q), .onehot(mode_onehot)
  );

  assign mode_code   = mode_q;
  assign saved_mode  = saved_q;
  assign rsm_illegal = illegal_q;
endmodule

// File: rtl/cpu_mode_tracker_chk.sv
module cpu_mode_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cr_pe,
  input logic       smi_req,
  input logic       rsm_req,
  input logic [1:0] mode_code,
  input logic [3:0] mode_onehot,
  input logic [1:0] saved_mode,
  input logic       smi_pending,
  input logic       rsm_illegal
);
  // R5
  smi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 2'd3 && smi_req) |=> (mode_code == 2'd3 && saved_mode == $past(mode_code)));
  // R6
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd3 && rsm_req) |=> (mode_code == $past(saved_mode)));
  // R7
  saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd3 && !rsm_req) |=> $stable(saved_mode));
  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd3 && smi_req) |=> smi_pending);
  // R9
  illegal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 2'd3 && rsm_req) |=> rsm_illegal);
  // R9
  illegal_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_code != 2'd3 && rsm_req) |=> !rsm_illegal);
  // R10
  real_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'd0 && !cr_pe && !smi_req && !smi_pending) |=> mode_code == 2'd0);
  // R11
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mode_onehot) == 1 && mode_onehot[mode_code]));
endmodule

bind cpu_mode_tracker cpu_mode_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cr_pe(cr_pe), .smi_req(smi_req),
  .rsm_req(rsm_req), .mode_code(mode_code), .mode_onehot(mode_onehot),
  .saved_mode(saved_mode), .smi_pending(smi_pending), .rsm_illegal(rsm_illegal)
);

// File: tb/cpu_mode_tracker_test.sv
`timescale 1ns/1ps
module cpu_mode_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cr_pe, cr_vm, smi_req, rsm_req;
  logic [1:0] mode_code, saved_mode;
  logic [3:0] mode_onehot;
  logic       smi_pending, rsm_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  logic [1:0] m_mode, m_saved;
  logic       m_pend, m_ill;

  always #5 clk = ~clk;

  cpu_mode_tracker uut (
    .clk(clk), .rst_n(rst_n), .cr_pe(cr_pe), .cr_vm(cr_vm),
    .smi_req(smi_req), .rsm_req(rsm_req), .mode_code(mode_code),
    .mode_onehot(mode_onehot), .saved_mode(saved_mode),
    .smi_pending(smi_pending), .rsm_illegal(rsm_illegal)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock of the requirements, applied to the model
  task automatic model_step(input logic pe, input logic vm, input logic smi, input logic rsm);
    logic [1:0] nm;
    logic [1:0] ns;
    logic       np;
    nm = m_mode; ns = m_saved; np = m_pend;
    if (m_mode == 2'd3) begin
      if (smi) np = 1'b1;            // R8
      if (rsm) nm = m_saved;          // R6
    end else if (smi || m_pend) begin // R5
      nm = 2'd3; ns = m_mode; np = 1'b0;
    end else begin
      case (m_mode)
        2'd0: if (pe) nm = 2'd1;                        // R2
        2'd1: if (!pe) nm = 2'd0; else if (vm) nm = 2'd2; // R3 R4
        2'd2: if (!vm) nm = 2'd1;                       // R4
        default: ;
      endcase
    end
    m_ill   = rsm && (m_mode != 2'd3);  // R9
    m_mode  = nm; m_saved = ns; m_pend = np;
  endtask

  task automatic compare_all(input string tag);
    check({tag, " mode"},    {2'b0, mode_code},  {2'b0, m_mode});
    check({tag, " saved"},   {2'b0, saved_mode}, {2'b0, m_saved});
    check({tag, " pending"}, {3'b0, smi_pending}, {3'b0, m_pend});
    check({tag, " illegal"}, {3'b0, rsm_illegal}, {3'b0, m_ill});
    check("R11 onehot", mode_onehot, 4'b0001 << mode_code);
  endtask

  task automatic step(input logic pe, input logic vm, input logic smi, input logic rsm,
                      input string tag);
    cr_pe = pe; cr_vm = vm; smi_req = smi; rsm_req = rsm;
    model_step(pe, vm, smi, rsm);
    @(posedge clk); #2;
    compare_all(tag);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    int seed;
    logic pe, vm;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; cr_pe = 0; cr_vm = 0; smi_req = 0; rsm_req = 0;
    m_mode = 0; m_saved = 0; m_pend = 0; m_ill = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1 after release");

    // directed corner cases
    step(0, 1, 0, 0, "R10 vm in real");
    step(1, 0, 0, 0, "R2 pe set");
    step(1, 1, 0, 0, "R4 enter v86");
    step(0, 1, 0, 0, "R10 pe in v86");
    step(0, 1, 0, 1, "R9 rsm in v86");
    step(0, 1, 1, 0, "R5 smi from v86");
    step(0, 0, 0, 0, "R10 flags in mgmt");
    step(0, 0, 1, 0, "R8 smi in mgmt");
    step(0, 0, 0, 0, "R7 saved held");
    step(0, 1, 0, 1, "R6 resume to v86");
    step(0, 1, 0, 0, "R8 pending taken");
    step(0, 1, 0, 1, "R6 resume again");
    step(0, 0, 0, 0, "R4 leave v86");
    step(0, 0, 0, 0, "R3 pe clear");
    step(0, 0, 1, 1, "R9 rsm with smi in real");
    step(0, 0, 1, 1, "R8 smi with rsm in mgmt");
    step(0, 0, 0, 0, "R8 taken after resume");
    step(1, 0, 0, 1, "R6 resume to real");
    step(1, 0, 0, 0, "R2 pe set");

    // constrained random
    pe = 1; vm = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) pe = ~pe;
      if ($urandom_range(0, 4) == 0) vm = ~vm;
      step(pe, vm, $urandom_range(0, 9) == 0, $urandom_range(0, 5) == 0, "R11 random");
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule